// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Flag Unit

This block produces the interrupt side of a battery-backed real-time clock. It holds the two control registers that choose the periodic rate and the interrupt enables, divides a 32.768 kHz tick down to the selected periodic rate, and merges three event sources into one interrupt line and one status register. The three sources are the periodic divider, an alarm-compare pulse and an update-ended pulse. Time and date counting, BCD handling and the host bus are outside the block: the compare result and the update pulse arrive as one-cycle inputs, and the control registers are loaded through simple write strobes.

Each event sets a fixed pattern of status flags. It raises the interrupt line only when its own enable is set. A read strobe on the status register hands the current value to the host and then clears every flag and drops the line. A one-cycle periodic pulse output shows when the divider completes a period. This lets the square-wave path use the divider even while the periodic interrupt is off.

Top module: `rtc_irq_unit`

## Requirements
- R1: In the cycle after a synchronous reset, the control register `cfg_a` reads 0x26, `cfg_b` reads 0x02, `stat` reads 0x00 and `irq` is low.
- R2: The rate code is `cfg_a[3:0]`. Codes 1 and 2 are used as codes 8 and 9, and any other code is used as given. A non-zero effective code c gives one periodic event every 2^(c-1) ticks. Code 0 gives no periodic events.
- R3: The divider counts ticks only while the periodic enable `cfg_b[6]` is set, or while the square-wave enable `cfg_b[3]` and `sqw_req` are both high. Otherwise the divider is held at zero. `per_pulse` is high for exactly one cycle, the cycle after the clock edge at which the tick that ends a period is taken.
- R4: A periodic event with `cfg_b[6]` set ORs 0xC0 into `stat` (bits 7 and 6) and raises `irq`, both visible together with `per_pulse`. With `cfg_b[6]` clear, a periodic event changes neither `stat` nor `irq`.
- R5: An `alarm_hit` pulse with the alarm enable `cfg_b[5]` set ORs 0xA0 into `stat` (bits 7 and 5) and raises `irq` one cycle later. With `cfg_b[5]` clear, the pulse has no effect.
- R6: Every `update_done` pulse sets the update flag `stat[4]` one cycle later. Only when the update enable `cfg_b[4]` is set does it also set `stat[7]` and raise `irq`.
- R7: In a cycle with `stat_rd` high, `stat` shows the flags gathered so far. From the next cycle, all flags are cleared and `irq` is low. The exception is any event taken in the read cycle itself: its flags and interrupt are kept.
- R8: Any write to `cfg_a` restarts the divider from zero. A period that would have ended in the write cycle is dropped.
- R9: `irq` is high exactly when `stat[7]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_a | input | 1 | Write strobe for control register A |
| wdata_a | input | 8 | Data for control register A |
| wr_b | input | 1 | Write strobe for control register B |
| wdata_b | input | 8 | Data for control register B |
| sqw_req | input | 1 | Square-wave output requested by the system |
| alarm_hit | input | 1 | One-cycle alarm-compare match |
| update_done | input | 1 | One-cycle update-ended event |
| stat_rd | input | 1 | Status register read strobe |
| cfg_a | output | 8 | Control register A (rate code in bits 3:0) |
| cfg_b | output | 8 | Control register B (enables in bits 6, 5, 4, 3) |
| stat | output | 8 | Status flags: 7 summary, 6 periodic, 5 alarm, 4 update |
| irq | output | 1 | Interrupt line |
| per_pulse | output | 1 | One-cycle periodic event marker |

## Verification
The hardest case is a status read that lands in the same cycle as a new event. Within that one cycle the read must clear the old flags while the new event keeps its own flags and its interrupt. Directed steps place an update-ended pulse on the read strobe, and the random phase mixes reads with alarm, update and periodic events at high density. A bench model applies clear-then-set ordering, and every cycle is compared against it. A second overlap is a register A write in the cycle a period would end. The bench provokes it by rewriting the rate code on random ticks, and it expects the event to be lost and the count to restart.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    parameter int DATA_W = 8;
    parameter int RATE_W = 4;
    // Largest effective code gives 2^(2^RATE_W - 2) ticks; counter reaches that minus one.
    localparam int CNT_W = (1 << RATE_W) - 2;

    // Flag positions in the status register.
    localparam int ST_SUM = 7;
    localparam int ST_PER = 6;
    localparam int ST_ALM = 5;
    localparam int ST_UPD = 4;

    // Reset contents of the control registers.
    localparam logic [DATA_W-1:0] CFG_A_RST = 8'h26;
    localparam logic [DATA_W-1:0] CFG_B_RST = 8'h02;

    // Field view of control register B.
    typedef struct packed {
        logic       b7;
        logic       per_en;
        logic       alm_en;
        logic       upd_en;
        logic       sqw_en;
        logic [2:0] low;
    } cfg_b_t;

    // One cycle's worth of events entering the flag logic.
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;

    // Enables seen by the flag logic.
    typedef struct packed {
        logic per_en;
        logic alm_en;
        logic upd_en;
    } en_t;

    // Low codes are folded onto slower rates.
    function automatic logic [RATE_W-1:0] eff_rate(input logic [RATE_W-1:0] code);
        logic [RATE_W-1:0] r;
        if (code == RATE_W'(1))
            r = RATE_W'(8);
        else if (code == RATE_W'(2))
            r = RATE_W'(9);
        else
            r = code;
        return r;
    endfunction

    // Terminal count for a code: 2^(eff-1) - 1, built bitwise.
    function automatic logic [CNT_W-1:0] last_count(input logic [RATE_W-1:0] code);
        logic [CNT_W-1:0] r;
        int               e;
        e = int'(eff_rate(code));
        for (int i = 0; i < CNT_W; i++)
            r[i] = (i < e - 1);
        return r;
    endfunction

endpackage

// File: rtl/rtc_irq_cfg.sv
module rtc_irq_cfg
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= CFG_A_RST;
            reg_b <= CFG_B_RST;
        end else begin
            if (wr_a)
                reg_a <= wdata_a;
            if (wr_b)
                reg_b <= wdata_b;
        end
    end

    // Any rate write restarts the divider in the same cycle.
    assign restart = wr_a;

endmodule

// File: rtl/rtc_irq_div.sv
module rtc_irq_div
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic              run_en,
    input  logic [RATE_W-1:0] rate,
    output logic              fire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             run;
    logic             at_end;

    assign lim    = last_count(rate);
    assign run    = run_en && (rate != '0);
    assign at_end = (cnt_q == lim);
    assign fire   = run && tick && at_end && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  en_t               en,
    input  logic              rd,
    output logic [DATA_W-1:0] flags,
    output logic              line
);

    logic [DATA_W-1:0] set_v;
    logic              raise;

    always_comb begin
        set_v = '0;
        raise = 1'b0;
        if (evt.per && en.per_en) begin
            set_v[ST_SUM] = 1'b1;
            set_v[ST_PER] = 1'b1;
            raise         = 1'b1;
        end
        if (evt.alm && en.alm_en) begin
            set_v[ST_SUM] = 1'b1;
            set_v[ST_ALM] = 1'b1;
            raise         = 1'b1;
        end
        if (evt.upd) begin
            set_v[ST_UPD] = 1'b1;
            if (en.upd_en) begin
                set_v[ST_SUM] = 1'b1;
                raise         = 1'b1;
            end
        end
    end

    // Clear by read first, then merge this cycle's events.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            line  <= 1'b0;
        end else begin
            flags <= (rd ? '0 : flags) | set_v;
            line  <= (rd ? 1'b0 : line) | raise;
        end
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata_b,
    input  logic              sqw_req,
    input  logic              alarm_hit,
    input  logic              update_done,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] cfg_a,
    output logic [DATA_W-1:0] cfg_b,
    output logic [DATA_W-1:0] stat,
    output logic              irq,
    output logic              per_pulse
);

    logic   restart;
    logic   fire;
    logic   run_en;
    cfg_b_t bf;
    evt_t   evt;
    en_t    en;

    rtc_irq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (wr_a),
        .wdata_a (wdata_a),
        .wr_b    (wr_b),
        .wdata_b (wdata_b),
        .reg_a   (cfg_a),
        .reg_b   (cfg_b),
        .restart (restart)
    );

    assign bf     = cfg_b_t'(cfg_b);
    assign run_en = bf.per_en || (bf.sqw_en && sqw_req);

    rtc_irq_div u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .run_en  (run_en),
        .rate    (cfg_a[RATE_W-1:0]),
        .fire    (fire)
    );

    assign evt = '{per: fire, alm: alarm_hit, upd: update_done};
    assign en  = '{per_en: bf.per_en, alm_en: bf.alm_en, upd_en: bf.upd_en};

    rtc_irq_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .en    (en),
        .rd    (stat_rd),
        .flags (stat),
        .line  (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            per_pulse <= 1'b0;
        else
            per_pulse <= fire;
    end

endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       alarm_hit,
    input logic       update_done,
    input logic       stat_rd,
    input logic [7:0] cfg_a,
    input logic [7:0] cfg_b,
    input logic [7:0] stat,
    input logic       irq,
    input logic       per_pulse
);

    AST_IRQ_FOLLOWS_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        irq == stat[7]); // R9

    AST_UPDATE_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        update_done |=> stat[4]); // R6

    AST_ALARM_FLAGS_SET: assert property (@(posedge clk) disable iff (rst)
        (alarm_hit && cfg_b[5]) |=> (stat[7] && stat[5] && irq)); // R5

    AST_PERIODIC_FLAGS_SET: assert property (@(posedge clk) disable iff (rst)
        (per_pulse && $past(cfg_b[6])) |-> (stat[7] && stat[6])); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        per_pulse |=> !per_pulse); // R3

    AST_NO_EVENT_RATE_ZERO: assert property (@(posedge clk) disable iff (rst)
        per_pulse |-> ($past(cfg_a[3:0]) != 4'd0)); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !alarm_hit && !update_done) |=> (per_pulse || (stat == 8'h00 && !irq))); // R7

endmodule

bind rtc_irq_unit rtc_irq_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .alarm_hit   (alarm_hit),
    .update_done (update_done),
    .stat_rd     (stat_rd),
    .cfg_a       (cfg_a),
    .cfg_b       (cfg_b),
    .stat        (stat),
    .irq         (irq),
    .per_pulse   (per_pulse)
);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, wr_a = 1'b0, wr_b = 1'b0, sqw_req = 1'b0;
    logic       alarm_hit = 1'b0, update_done = 1'b0, stat_rd = 1'b0;
    logic [7:0] wdata_a = 8'h00, wdata_b = 8'h00;
    logic [7:0] cfg_a, cfg_b, stat;
    logic       irq, per_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int stepno = 0;
    int last_pulse = 0;
    int gap = 0;

    // Bench model state
    logic [7:0] m_a, m_b, m_stat;
    logic       m_irq, m_pulse;
    int         m_cnt;

    always #10 clk = ~clk;

    rtc_irq_unit u_rtc_irq_unit (
        .clk(clk), .rst(rst), .tick(tick), .wr_a(wr_a), .wdata_a(wdata_a),
        .wr_b(wr_b), .wdata_b(wdata_b), .sqw_req(sqw_req), .alarm_hit(alarm_hit),
        .update_done(update_done), .stat_rd(stat_rd), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .stat(stat), .irq(irq), .per_pulse(per_pulse)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic int ticks_for(input logic [3:0] code);
        int e;
        e = (code == 4'd1) ? 8 : (code == 4'd2) ? 9 : int'(code);
        return 1 << (e - 1);
    endfunction

    task automatic step(input logic tk, input logic al, input logic up, input logic rd,
                        input logic wa, input logic [7:0] da,
                        input logic wb, input logic [7:0] db, input logic sq);
        logic       run, fire, raise;
        logic [7:0] setv;
        int         per;
        @(negedge clk);
        tick = tk; alarm_hit = al; update_done = up; stat_rd = rd;
        wr_a = wa; wdata_a = da; wr_b = wb; wdata_b = db; sqw_req = sq;
        #1;
        if (rd) chk(stat == m_stat, "R7 value shown in read cycle", stat, m_stat);
        run  = (m_a[3:0] != 4'd0) && (m_b[6] || (m_b[3] && sq));
        per  = ticks_for(m_a[3:0]);
        fire = run && tk && !wa && (m_cnt == per - 1);
        setv = 8'h00;
        raise = 1'b0;
        if (fire && m_b[6]) begin setv |= 8'hC0; raise = 1'b1; end
        if (al && m_b[5])   begin setv |= 8'hA0; raise = 1'b1; end
        if (up) begin
            setv |= 8'h10;
            if (m_b[4]) begin setv |= 8'h80; raise = 1'b1; end
        end
        if (wa || !run)  m_cnt = 0;
        else if (tk)     m_cnt = (m_cnt == per - 1) ? 0 : m_cnt + 1;
        m_stat  = (rd ? 8'h00 : m_stat) | setv;
        m_irq   = (rd ? 1'b0 : m_irq) | raise;
        m_pulse = fire;
        if (wa) m_a = da;
        if (wb) m_b = db;
        @(posedge clk);
        #1;
        stepno++;
        chk(stat == m_stat, "R4/R5/R6/R7 stat", stat, m_stat);
        chk(irq == m_irq, "R4/R5/R6/R7/R9 irq", irq, m_irq);
        chk(per_pulse == m_pulse, "R2/R3/R8 per_pulse", per_pulse, m_pulse);
        chk(cfg_a == m_a && cfg_b == m_b, "R1 control registers", {cfg_a, cfg_b}, {m_a, m_b});
        if (per_pulse) begin
            gap = stepno - last_pulse;
            last_pulse = stepno;
        end
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) step(tk, 0, 0, 0, 0, 8'h00, 0, 8'h00, sqw_req);
    endtask

    task automatic measure(input logic [3:0] code, input string tag);
        step(0, 0, 0, 1, 1, {4'h2, code}, 1, 8'h40, 0);
        idle(ticks_for(code) + 2, 1);
        idle(ticks_for(code), 1);
        chk(gap == ticks_for(code), tag, gap, ticks_for(code));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_a = 8'h26; m_b = 8'h02; m_stat = 8'h00; m_irq = 1'b0; m_pulse = 1'b0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset contents
        chk(cfg_a == 8'h26, "R1 cfg_a reset", cfg_a, 8'h26);
        chk(cfg_b == 8'h02, "R1 cfg_b reset", cfg_b, 8'h02);
        chk(stat == 8'h00 && irq == 1'b0, "R1 stat/irq reset", {stat, 7'b0, irq}, 0);

        // R2 period lengths, including the folded low codes
        measure(4'd3, "R2 code 3 period");
        measure(4'd1, "R2 code 1 folded to 8");
        measure(4'd2, "R2 code 2 folded to 9");
        measure(4'd15, "R2 code 15 period");
        step(0, 0, 0, 1, 1, 8'h20, 0, 8'h00, 0);
        last_pulse = stepno;
        idle(300, 1);
        chk(last_pulse == stepno - 300, "R2 code 0 no events", last_pulse, stepno - 300);

        // R3 square-wave path runs the divider without flags
        step(0, 0, 0, 1, 1, 8'h23, 1, 8'h08, 1);
        idle(12, 1);
        chk(gap == 4 && stat == 8'h00, "R3 sqw runs divider, R4 no flags", {gap[7:0], stat}, 16'h0400);
        sqw_req = 1'b0;
        last_pulse = stepno;
        idle(20, 1);
        chk(last_pulse == stepno - 20, "R3 divider held without enable", last_pulse, stepno - 20);

        // R5 alarm with enable clear has no effect
        step(0, 1, 0, 0, 0, 8'h00, 1, 8'h00, 0);
        step(0, 1, 0, 0, 0, 8'h00, 0, 8'h00, 0);
        chk(stat == 8'h00 && !irq, "R5 alarm ignored when disabled", stat, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 1, 8'h20, 0);
        step(0, 1, 0, 0, 0, 8'h00, 0, 8'h00, 0);
        chk(stat == 8'hA0 && irq, "R5 alarm flags", stat, 8'hA0);

        // R6 update without enable: flag only
        step(0, 0, 0, 1, 0, 8'h00, 1, 8'h00, 0);
        step(0, 0, 1, 0, 0, 8'h00, 0, 8'h00, 0);
        chk(stat == 8'h10 && !irq, "R6 update flag only", stat, 8'h10);

        // R7 read and update in the same cycle keep the new event
        step(0, 0, 0, 0, 0, 8'h00, 1, 8'h10, 0);
        step(0, 1, 1, 1, 0, 8'h00, 0, 8'h00, 0);
        chk(stat == 8'h90 && irq, "R7 same-cycle update survives read", stat, 8'h90);
        step(0, 0, 0, 1, 0, 8'h00, 0, 8'h00, 0);
        chk(stat == 8'h00 && !irq, "R7 read clears", stat, 8'h00);

        // R8 rewrite of rate code restarts count
        step(0, 0, 0, 0, 1, 8'h23, 1, 8'h40, 0);
        idle(3, 1);
        step(1, 0, 0, 0, 1, 8'h23, 0, 8'h00, 0);
        chk(!per_pulse, "R8 event dropped on write", per_pulse, 0);
        idle(3, 1);
        chk(!per_pulse, "R8 restart not yet ended", per_pulse, 0);
        idle(1, 1);
        chk(per_pulse && stat == 8'hC0, "R8 restarted period, R4 flags", stat, 8'hC0);

        // Random mix
        for (int i = 0; i < 20000; i++) begin
            logic       tk, al, up, rd, wa, wb, sq;
            logic [7:0] da, db;
            tk = ($urandom % 2) == 0;
            al = ($urandom % 7) == 0;
            up = ($urandom % 6) == 0;
            rd = ($urandom % 5) == 0;
            wa = ($urandom % 150) == 0;
            wb = ($urandom % 60) == 0;
            sq = ($urandom % 4) != 0;
            da = {4'($urandom), 4'($urandom % 7)};
            db = 8'($urandom);
            step(tk, al, up, rd, wa, da, wb, db, sq);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule